// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block receives configuration frames on a single serial data line and places the values in a small bank of 8-bit control registers. Each frame is eleven bits long: a 3-bit register address followed by an 8-bit value. Data bits are sampled on the rising edge of the slow system clock. The finished word is written when a load strobe is high at a falling edge of that clock. A bank-select input chooses the target. When it is high, the eight main registers are addressed directly. When it is low, only two extra registers can be reached.

All registers are presented in parallel on one flat output bus, and the rest of the sensor reads its settings from there. Register 0 holds a 2-bit black-calibration field in bits 7:6 and a 6-bit offset field in bits 5:0. Register 1 holds the edge-enhancement enable in bit 7, a 2-bit edge-direction field in bits 6:5 and a 5-bit gain field in bits 4:0. While that enable bit is set, the block substitutes fixed codes into the filter-line fields of registers 4 and 5 and write-protects those fields.

Top module: `sensor_cfg_regs`

## Requirements
- R1: A frame is sent most significant bit first: 3 address bits, then 8 data bits, one bit per rising clock edge taken from `sdata_i`.
- R2: A word is written at a falling clock edge where `load_i` is high. The register output changes at that falling edge and not before it.
- R3: If fewer than 11 bits have been shifted in since the last restart, a load strobe writes nothing.
- R4: With `bank_sel_i` = 1, address n selects register n (0 to 7). With `bank_sel_i` = 0, address 001 selects register 8 and address 010 selects register 9. Register k appears on `regs_o[8k+7:8k]`.
- R5: With `bank_sel_i` = 0, any address other than 001 or 010 leaves every register unchanged.
- R6: While register 1 bit 7 is 1, `regs_o` shows register 4 bits 3:0 as 0x2 and register 5 bits 3:0 as 0x5. Writes to those two nibbles are ignored, but the upper nibbles are still written. When bit 7 is cleared, the stored nibbles from before the override appear again.
- R7: Holding `rst_logic_n` and `rst_reg_n` low together clears all registers to 0x00. Either reset low on its own leaves the registers intact. `rst_logic_n` low on its own discards a frame that is only partly received.
- R8: A rising edge with `load_i` high shifts no bit and restarts the bit count. A frame longer than 11 bits keeps only its last 11 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock: bits are sampled on the rising edge and writes happen on the falling edge |
| rst_logic_n | input | 1 | Active-low reset of the serial receiver |
| rst_reg_n | input | 1 | Active-low register reset; it clears the registers only when `rst_logic_n` is also low |
| sdata_i | input | 1 | Serial frame data |
| load_i | input | 1 | Load strobe that commits the assembled word |
| bank_sel_i | input | 1 | 1 selects the main bank; 0 selects the two extra registers |
| regs_o | output | 80 | Register contents, with register k at bits 8k+7:8k and the override applied |

## Verification
The bench sends a frame of fourteen bits. A design that kept the first eleven bits instead of the last eleven would write 0x6B to register 5 rather than 0x5A to register 3. The bench sends a 7-bit fragment and then a 4-bit fragment, which together would spell a write of 0xFF to register 0. A counter that did not restart on the strobe would let those fragments combine and overwrite register 0. The bench also tries the illegal extra-bank addresses. It sets and clears the edge-enhancement bit around writes to registers 4 and 5: a design that lost the stored nibbles, or blocked the upper nibbles, would show wrong values after the override ends. It checks the output just before and just after the falling edge. It pulses each reset on its own and then both together, which separates a design that clears on either reset from one that needs both.

// File: rtl/sensor_cfg_pkg.sv
package sensor_cfg_pkg;

   // Register index wide enough for any legal bank size (checked at elaboration)
   localparam int unsigned REG_IDX_W = 8;

   typedef logic [REG_IDX_W-1:0] reg_idx_t;

   // Result of decoding a frame address against the bank selection
   typedef struct packed {
      logic     legal;
      reg_idx_t idx;
   } dec_t;

endpackage

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdata_i,
   input  logic              load_i,
   output logic              frame_ok_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int unsigned FRAME_LEN = ADDR_W + DATA_W;
   localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);

   logic [FRAME_LEN-1:0] shreg;
   logic [CNT_W-1:0]     count;

   // Rising-edge capture: MSB arrives first, so bits move toward the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         count <= '0;
      end else if (load_i) begin
         count <= '0;
      end else begin
         shreg <= {shreg[FRAME_LEN-2:0], sdata_i};
         if (count != CNT_FULL) begin
            count <= count + 1'b1;
         end
      end
   end

   assign frame_ok_o = (count == CNT_FULL);
   assign addr_o     = shreg[FRAME_LEN-1 -: ADDR_W];
   assign data_o     = shreg[DATA_W-1:0];

endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
   import sensor_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned MAIN_REGS = 8,
   parameter int unsigned EXT_REGS  = 2,
   parameter int unsigned EXT_BASE  = 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              bank_sel_i,
   output dec_t              dec_o
);

   logic [31:0] addr_u;

   assign addr_u = 32'(addr_i);

   always_comb begin
      dec_o = '0;
      if (bank_sel_i) begin
         if (addr_u < MAIN_REGS) begin
            dec_o.legal = 1'b1;
            dec_o.idx   = reg_idx_t'(addr_u);
         end
      end else if ((addr_u >= EXT_BASE) && (addr_u < EXT_BASE + EXT_REGS)) begin
         dec_o.legal = 1'b1;
         dec_o.idx   = reg_idx_t'(MAIN_REGS + addr_u - EXT_BASE);
      end
   end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import sensor_cfg_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_REGS  = 10,
   parameter int unsigned EDGE_REG  = 1,
   parameter int unsigned EDGE_BIT  = 7,
   parameter int unsigned POS_REG   = 4,
   parameter int unsigned NEG_REG   = 5,
   parameter int unsigned LINE_W    = 4,
   parameter int unsigned POS_FORCE = 2,
   parameter int unsigned NEG_FORCE = 5
) (
   input  logic                       clk,
   input  logic                       clear_n,
   input  logic                       wr_en_i,
   input  reg_idx_t                   wr_idx_i,
   input  logic [DATA_W-1:0]          wr_data_i,
   output logic                       edge_en_o,
   output logic [NUM_REGS*DATA_W-1:0] rd_flat_o
);

   logic [NUM_REGS*DATA_W-1:0] stored_flat;

   assign edge_en_o = stored_flat[EDGE_REG*DATA_W + EDGE_BIT];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      logic              hit;

      assign hit = wr_en_i && (wr_idx_i == reg_idx_t'(i));
      assign stored_flat[i*DATA_W +: DATA_W] = q;

      if ((i == POS_REG) || (i == NEG_REG)) begin : g_locked
         localparam logic [LINE_W-1:0] FORCE_VAL =
            (i == POS_REG) ? LINE_W'(POS_FORCE) : LINE_W'(NEG_FORCE);

         // Upper field is always writable; the line field only without override
         always_ff @(negedge clk or negedge clear_n) begin
            if (!clear_n) begin
               q <= '0;
            end else if (hit) begin
               q[DATA_W-1:LINE_W] <= wr_data_i[DATA_W-1:LINE_W];
               if (!edge_en_o) begin
                  q[LINE_W-1:0] <= wr_data_i[LINE_W-1:0];
               end
            end
         end

         assign rd_flat_o[i*DATA_W +: DATA_W] =
            edge_en_o ? {q[DATA_W-1:LINE_W], FORCE_VAL} : q;
      end else begin : g_plain
         always_ff @(negedge clk or negedge clear_n) begin
            if (!clear_n) begin
               q <= '0;
            end else if (hit) begin
               q <= wr_data_i;
            end
         end

         assign rd_flat_o[i*DATA_W +: DATA_W] = q;
      end
   end

endmodule

// File: rtl/sensor_cfg_regs.sv
module sensor_cfg_regs
   import sensor_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned EXT_REGS  = 2,
   parameter int unsigned EXT_BASE  = 1,
   parameter int unsigned EDGE_REG  = 1,
   parameter int unsigned EDGE_BIT  = 7,
   parameter int unsigned POS_REG   = 4,
   parameter int unsigned NEG_REG   = 5,
   parameter int unsigned LINE_W    = 4,
   parameter int unsigned POS_FORCE = 2,
   parameter int unsigned NEG_FORCE = 5
) (
   input  logic                                  clk,
   input  logic                                  rst_logic_n,
   input  logic                                  rst_reg_n,
   input  logic                                  sdata_i,
   input  logic                                  load_i,
   input  logic                                  bank_sel_i,
   output logic [((2**ADDR_W)+EXT_REGS)*DATA_W-1:0] regs_o
);

   localparam int unsigned MAIN_REGS = 2**ADDR_W;
   localparam int unsigned NUM_REGS  = MAIN_REGS + EXT_REGS;

   // Elaboration-time parameter checks
   if (NUM_REGS > 2**REG_IDX_W) begin : g_chk_idx
      $error("register count exceeds index width");
   end
   if (EXT_BASE + EXT_REGS > MAIN_REGS) begin : g_chk_ext
      $error("extra-bank addresses do not fit the address field");
   end
   if ((LINE_W == 0) || (LINE_W >= DATA_W)) begin : g_chk_line
      $error("line field must be narrower than a register");
   end
   if ((EDGE_REG == POS_REG) || (EDGE_REG == NEG_REG) || (POS_REG == NEG_REG)) begin : g_chk_roles
      $error("enable, positive and negative registers must differ");
   end
   if ((EDGE_BIT >= DATA_W) || (POS_REG >= NUM_REGS) || (NEG_REG >= NUM_REGS)
       || (EDGE_REG >= NUM_REGS)) begin : g_chk_range
      $error("register role out of range");
   end
   if ((POS_FORCE >= 2**LINE_W) || (NEG_FORCE >= 2**LINE_W)) begin : g_chk_force
      $error("forced code does not fit the line field");
   end

   logic              clear_n;
   logic              frame_ok;
   logic [ADDR_W-1:0] frame_addr;
   logic [DATA_W-1:0] frame_data;
   dec_t              dec;
   logic              wr_en;
   logic              edge_en;

   // Registers clear only while both resets are low
   assign clear_n = rst_logic_n | rst_reg_n;

   cfg_frame_shifter #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_shifter (
      .clk        (clk),
      .rst_n      (rst_logic_n),
      .sdata_i    (sdata_i),
      .load_i     (load_i),
      .frame_ok_o (frame_ok),
      .addr_o     (frame_addr),
      .data_o     (frame_data)
   );

   cfg_addr_decode #(
      .ADDR_W    (ADDR_W),
      .MAIN_REGS (MAIN_REGS),
      .EXT_REGS  (EXT_REGS),
      .EXT_BASE  (EXT_BASE)
   ) i_decode (
      .addr_i     (frame_addr),
      .bank_sel_i (bank_sel_i),
      .dec_o      (dec)
   );

   assign wr_en = load_i && frame_ok && dec.legal;

   cfg_reg_bank #(
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .EDGE_REG  (EDGE_REG),
      .EDGE_BIT  (EDGE_BIT),
      .POS_REG   (POS_REG),
      .NEG_REG   (NEG_REG),
      .LINE_W    (LINE_W),
      .POS_FORCE (POS_FORCE),
      .NEG_FORCE (NEG_FORCE)
   ) i_bank (
      .clk       (clk),
      .clear_n   (clear_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (dec.idx),
      .wr_data_i (frame_data),
      .edge_en_o (edge_en),
      .rd_flat_o (regs_o)
   );

endmodule

// File: rtl/cfg_regs_chk.sv
module cfg_regs_chk
   import sensor_cfg_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_REGS  = 10,
   parameter int unsigned POS_REG   = 4,
   parameter int unsigned NEG_REG   = 5,
   parameter int unsigned LINE_W    = 4,
   parameter int unsigned POS_FORCE = 2,
   parameter int unsigned NEG_FORCE = 5
) (
   input logic                       clk,
   input logic                       rst_logic_n,
   input logic                       load_i,
   input logic                       frame_ok,
   input logic                       wr_legal,
   input reg_idx_t                   wr_idx,
   input logic [DATA_W-1:0]          wr_data,
   input logic                       edge_en,
   input logic [NUM_REGS*DATA_W-1:0] regs_o
);

   logic              last_commit;
   reg_idx_t          last_idx;
   logic [DATA_W-1:0] last_data;

   always_ff @(negedge clk or negedge rst_logic_n) begin
      if (!rst_logic_n) begin
         last_commit <= 1'b0;
         last_idx    <= '0;
         last_data   <= '0;
      end else begin
         last_commit <= load_i && frame_ok && wr_legal
                        && (wr_idx != reg_idx_t'(POS_REG))
                        && (wr_idx != reg_idx_t'(NEG_REG));
         last_idx    <= wr_idx;
         last_data   <= wr_data;
      end
   end

   // R4: a legal complete frame lands in the decoded register
   a_r4_commit_value: assert property (@(negedge clk) disable iff (!rst_logic_n)
      last_commit |-> (regs_o[32'(last_idx)*DATA_W +: DATA_W] == last_data));

   // R2: no strobe, no change
   a_r2_hold_without_load: assert property (@(negedge clk) disable iff (!rst_logic_n)
      !load_i |=> $stable(regs_o));

   // R3: strobe on an incomplete frame writes nothing
   a_r3_short_frame_ignored: assert property (@(negedge clk) disable iff (!rst_logic_n)
      (load_i && !frame_ok) |=> $stable(regs_o));

   // R5: illegal address writes nothing
   a_r5_illegal_ignored: assert property (@(negedge clk) disable iff (!rst_logic_n)
      (load_i && !wr_legal) |=> $stable(regs_o));

   // R6: override codes visible while the enable is set
   a_r6_forced_lines: assert property (@(posedge clk) disable iff (!rst_logic_n)
      edge_en |-> ((regs_o[POS_REG*DATA_W +: LINE_W] == LINE_W'(POS_FORCE))
                && (regs_o[NEG_REG*DATA_W +: LINE_W] == LINE_W'(NEG_FORCE))));

endmodule

bind sensor_cfg_regs cfg_regs_chk #(
   .DATA_W    (DATA_W),
   .NUM_REGS  (NUM_REGS),
   .POS_REG   (POS_REG),
   .NEG_REG   (NEG_REG),
   .LINE_W    (LINE_W),
   .POS_FORCE (POS_FORCE),
   .NEG_FORCE (NEG_FORCE)
) i_chk (
   .clk         (clk),
   .rst_logic_n (rst_logic_n),
   .load_i      (load_i),
   .frame_ok    (frame_ok),
   .wr_legal    (dec.legal),
   .wr_idx      (dec.idx),
   .wr_data     (frame_data),
   .edge_en     (edge_en),
   .regs_o      (regs_o)
);

// File: tb/test_sensor_cfg_regs.sv
module test_sensor_cfg_regs;

   logic        clk = 1'b0;
   logic        rst_logic_n = 1'b0;
   logic        rst_reg_n = 1'b0;
   logic        sdata = 1'b0;
   logic        load = 1'b0;
   logic        bank_sel = 1'b1;
   logic [79:0] regs;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] model [10];

   always #5 clk = ~clk;

   sensor_cfg_regs i_sensor_cfg_regs (
      .clk         (clk),
      .rst_logic_n (rst_logic_n),
      .rst_reg_n   (rst_reg_n),
      .sdata_i     (sdata),
      .load_i      (load),
      .bank_sel_i  (bank_sel),
      .regs_o      (regs)
   );

   function automatic logic [7:0] view(input int i);
      logic [7:0] v = model[i];
      if (model[1][7] && i == 4) v[3:0] = 4'h2;
      if (model[1][7] && i == 5) v[3:0] = 4'h5;
      return v;
   endfunction

   function automatic void model_write(input logic bank, input logic [2:0] a, input logic [7:0] d);
      int idx;
      if (bank) idx = int'(a);
      else if (a == 3'd1) idx = 8;
      else if (a == 3'd2) idx = 9;
      else return;
      if ((idx == 4 || idx == 5) && model[1][7]) model[idx][7:4] = d[7:4];
      else model[idx] = d;
   endfunction

   task automatic check_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < 10; i++) check_val($sformatf("%s reg%0d", tag, i), regs[i*8 +: 8], view(i));
   endtask

   task automatic shift_bits(input logic [15:0] bits, input int n);
      for (int k = n - 1; k >= 0; k--) begin
         @(negedge clk); #1 sdata = bits[k];
         @(posedge clk);
      end
   endtask

   task automatic strobe();
      #1 load = 1'b1;
      @(negedge clk); #2;
      @(posedge clk); #1 load = 1'b0;
   endtask

   task automatic write_frame(input logic bank, input logic [2:0] a, input logic [7:0] d);
      bank_sel = bank;
      shift_bits({5'b0, a, d}, 11);
      strobe();
      model_write(bank, a, d);
   endtask

   task automatic t_reset_state();
      check_all("R7 reset state");
   endtask

   task automatic t_main_bank();
      for (int a = 0; a < 8; a++) write_frame(1'b1, 3'(a), 8'(8'h11 * (a + 1)) ^ 8'h0F);
      check_all("R1 R4 main bank");
   endtask

   task automatic t_commit_edge();
      bank_sel = 1'b1;
      shift_bits({5'b0, 3'd6, 8'hC3}, 11);
      #1 load = 1'b1;
      #1 check_val("R2 before falling edge", regs[6*8 +: 8], view(6));
      @(negedge clk); #1;
      model_write(1'b1, 3'd6, 8'hC3);
      check_val("R2 at falling edge", regs[6*8 +: 8], view(6));
      @(posedge clk); #1 load = 1'b0;
   endtask

   task automatic t_ext_bank();
      write_frame(1'b0, 3'd1, 8'hA5);
      write_frame(1'b0, 3'd2, 8'h3C);
      check_val("R4 ext reg8", regs[8*8 +: 8], 8'hA5);
      check_val("R4 ext reg9", regs[9*8 +: 8], 8'h3C);
      check_all("R4 ext bank");
   endtask

   task automatic t_illegal_ext();
      write_frame(1'b0, 3'd0, 8'hEE);
      write_frame(1'b0, 3'd3, 8'hEE);
      write_frame(1'b0, 3'd7, 8'hEE);
      check_all("R5 illegal ext address");
   endtask

   task automatic t_long_frame();
      bank_sel = 1'b1;
      shift_bits(16'b00_101_011_01011010, 14);
      strobe();
      model_write(1'b1, 3'd3, 8'h5A);
      check_val("R8 last eleven bits", regs[3*8 +: 8], 8'h5A);
      check_all("R8 long frame");
   endtask

   task automatic t_short_frame();
      bank_sel = 1'b1;
      shift_bits(16'b0001111, 7);
      strobe();
      shift_bits(16'b1111, 4);
      strobe();
      check_all("R3 short fragments");
   endtask

   task automatic t_edge_override();
      write_frame(1'b1, 3'd4, 8'hA9);
      write_frame(1'b1, 3'd5, 8'h3C);
      write_frame(1'b1, 3'd1, 8'h85);
      check_val("R6 forced pos", regs[4*8 +: 8], 8'hA2);
      check_val("R6 forced neg", regs[5*8 +: 8], 8'h35);
      write_frame(1'b1, 3'd4, 8'h77);
      write_frame(1'b1, 3'd5, 8'hD1);
      check_val("R6 upper written pos", regs[4*8 +: 8], 8'h72);
      check_val("R6 upper written neg", regs[5*8 +: 8], 8'hD5);
      write_frame(1'b1, 3'd1, 8'h05);
      check_val("R6 restored pos", regs[4*8 +: 8], 8'h79);
      check_val("R6 restored neg", regs[5*8 +: 8], 8'hDC);
      check_all("R6 after override");
   endtask

   task automatic t_resets();
      @(posedge clk); #1 rst_reg_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_reg_n = 1'b1;
      check_all("R7 register reset alone");
      bank_sel = 1'b1;
      shift_bits({5'b0, 3'd2, 8'h99} >> 5, 6);
      #1 rst_logic_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_logic_n = 1'b1;
      shift_bits({5'b0, 3'd2, 8'h99}, 5);
      strobe();
      check_all("R7 logic reset alone");
      #1 rst_logic_n = 1'b0; rst_reg_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_logic_n = 1'b1; rst_reg_n = 1'b1;
      for (int i = 0; i < 10; i++) model[i] = 8'h00;
      check_all("R7 both resets");
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 10; i++) model[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_logic_n = 1'b1; rst_reg_n = 1'b1;
      @(posedge clk); #2;
      t_reset_state();
      t_main_bank();
      t_commit_edge();
      t_ext_bank();
      t_illegal_ext();
      t_long_frame();
      t_short_frame();
      t_edge_override();
      t_resets();
      done = 1'b1;
      finish_run();
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

endmodule